// File: doc/BRIEF.md
# DMA Completion Interrupt Register

This block holds one 32-bit control and status word for a multi-channel DMA engine. Software writes it to set per-channel interrupt enables, a master enable, a bus-fault bit and six spare control bits. Each channel's transfer logic raises a one-cycle completion strobe, which latches a per-channel flag if that channel is enabled. Software acknowledges a flag by writing a 1 to its position. Writing 0 there leaves the flag alone.

When either of two conditions holds, the block sends a single-cycle request to the system interrupt controller. The first condition is that the master enable is set and at least one flag is latched. The second is that the bus-fault bit is set. Bit 31 of the word records that a request has already been sent, so a condition that stays true produces only one request. The condition must go false and then true again before another request is sent.

A two-state machine models bit 31. In state QUIET no request has been sent. In state SIGNALLED a request has been sent. The transition RAISE (QUIET to SIGNALLED) happens on any clock edge where the updated word meets the condition, and it emits the request pulse. The transition DROP (SIGNALLED to QUIET) happens on any edge where the updated word no longer meets it. HOLD_QUIET and HOLD_SIGNALLED keep the state when the condition does not change.

Top module: `dma_irq_ctrl`

## Requirements
- R1: An active-low reset clears the whole word to 0 and holds `irq_pulse` low.
- R2: On a write, only the bits under mask 0x00FF803F are taken from `wr_data`. These are bits 5:0 (spare), bit 15 (bus fault), bits 22:16 (channel enables, channel n at bit 16+n) and bit 23 (master enable). Bits 14:6 always read 0.
- R3: On a write, flag bit 24+n is cleared where `wr_data` has a 1 and kept where it has a 0.
- R4: A strobe on `done_pulse[n]` sets flag bit 24+n only when enable bit 16+n is set. Otherwise it changes nothing.
- R5: After every clock edge, bit 31 equals the condition (bit 23 AND any of bits 30:24) OR bit 15. In particular, a write that makes the condition false leaves bit 31 clear.
- R6: `irq_pulse` is high for exactly the one cycle after the edge where bit 31 goes from 0 to 1. The cause can be a write or a completion strobe.
- R7: While bit 31 stays set, no further pulse is sent, even when more flags latch or the same fault bit is written again.
- R8: When a write and a completion strobe arrive in the same cycle, the write is merged first. The strobe then uses the enables from that merged value, and a flag that is both cleared and set in that cycle ends up set.
- R9: Writing bit 31 directly has no effect. It only follows the condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| done_pulse | input | NUM_CH | Per-channel completion strobes |
| rd_data | output | 32 | Current register word |
| irq_pulse | output | 1 | One-cycle request to set system interrupt status bit 3 |

## Verification
A software write and a channel completion strobe can arrive in the same cycle. The bench drives both on one edge in three cases:
- the write turns on the master enable and channel enable that the strobe relies on;
- the write acknowledges the flag that the strobe sets again;
- the write disables the channel that the strobe targets.

The resulting word and the pulse are judged against a behavioural model that merges the write first and applies the strobe second.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CH_LIMIT   = 7;
    localparam int unsigned EN_LSB     = 16;
    localparam int unsigned FLAG_LSB   = 24;
    localparam int unsigned MASTER_BIT = 23;
    localparam int unsigned FAULT_BIT  = 15;
    localparam int unsigned SENT_BIT   = 31;
    localparam logic [WORD_W-1:0] DIRECT_MASK = 32'h00FF_803F;

    typedef enum logic {
        ST_QUIET     = 1'b0,
        ST_SIGNALLED = 1'b1
    } sent_state_e;
endpackage

// File: rtl/dicr_write_merge.sv
module dicr_write_merge
    import dicr_pkg::*;
#(
    parameter int unsigned NUM_CH = 7
) (
    input  logic [WORD_W-1:0] cur_word,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] merged
);
    localparam logic [WORD_W-1:0] FLAG_MASK =
        WORD_W'(((1 << NUM_CH) - 1) << FLAG_LSB);

    logic [WORD_W-1:0] kept_flags;

    always_comb begin
        kept_flags = cur_word & ~wr_data & FLAG_MASK;
        if (wr_en) begin
            merged = (wr_data & DIRECT_MASK) | kept_flags;
        end else begin
            merged = cur_word & (DIRECT_MASK | FLAG_MASK);
        end
    end
endmodule

// File: rtl/dicr_flag_set.sv
module dicr_flag_set
    import dicr_pkg::*;
#(
    parameter int unsigned NUM_CH = 7
) (
    input  logic [WORD_W-1:0] merged,
    input  logic [NUM_CH-1:0] done_pulse,
    output logic [WORD_W-1:0] body,
    output logic              cond
);
    logic [NUM_CH-1:0] flag_next;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
        assign flag_next[n] = merged[FLAG_LSB+n] | (done_pulse[n] & merged[EN_LSB+n]);
    end

    always_comb begin
        body = merged;
        body[FLAG_LSB +: NUM_CH] = flag_next;
        body[SENT_BIT] = 1'b0;
        cond = (body[MASTER_BIT] & (|flag_next)) | body[FAULT_BIT];
    end
endmodule

// File: rtl/dicr_sent_fsm.sv
module dicr_sent_fsm
    import dicr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic sent,
    output logic irq_pulse
);
    sent_state_e state_q, state_d;

    // Next state: RAISE, DROP, or hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:     if (cond)  state_d = ST_SIGNALLED;  // RAISE
            ST_SIGNALLED: if (!cond) state_d = ST_QUIET;      // DROP
            default:      state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Output: pulse only on RAISE.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            unique case (state_q)
                ST_QUIET:     irq_pulse <= cond;
                ST_SIGNALLED: irq_pulse <= 1'b0;
                default:      irq_pulse <= 1'b0;
            endcase
        end
    end

    assign sent = (state_q == ST_SIGNALLED);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dicr_pkg::*;
#(
    parameter int unsigned NUM_CH = 7   // 1 .. CH_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [NUM_CH-1:0] done_pulse,
    output logic [31:0]       rd_data,
    output logic              irq_pulse
);
    logic [WORD_W-1:0] body_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] body_d;
    logic              cond;
    logic              sent;

    dicr_write_merge #(.NUM_CH(NUM_CH)) u_merge (
        .cur_word (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .merged   (merged)
    );

    dicr_flag_set #(.NUM_CH(NUM_CH)) u_flags (
        .merged     (merged),
        .done_pulse (done_pulse),
        .body       (body_d),
        .cond       (cond)
    );

    dicr_sent_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (cond),
        .sent      (sent),
        .irq_pulse (irq_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) body_q <= '0;
        else        body_q <= body_d;
    end

    always_comb begin
        rd_data = body_q;
        rd_data[SENT_BIT] = sent;
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
    parameter int unsigned NUM_CH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [NUM_CH-1:0] done_pulse,
    input logic [31:0]       rd_data,
    input logic              irq_pulse
);
    assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14:6] == '0);

    assert_sent_tracks_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] == ((rd_data[23] && (rd_data[30:24] != '0)) || rd_data[15]));

    assert_pulse_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[31]) |-> irq_pulse);

    assert_pulse_needs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (rd_data[31] && !$past(rd_data[31])));

    assert_no_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assert_flag_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_data[24+n]) |-> ($past(done_pulse[n]) && rd_data[16+n]));

        assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[24+n] && !done_pulse[n]) |=> !rd_data[24+n]);
    end
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .done_pulse (done_pulse),
    .rd_data    (rd_data),
    .irq_pulse  (irq_pulse)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done_pulse = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    logic [31:0] m_word = '0;
    logic        m_irq  = 1'b0;

    always #10 clk = ~clk;

    dma_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .done_pulse (done_pulse),
        .rd_data    (rd_data),
        .irq_pulse  (irq_pulse)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        logic [31:0] t;
        logic        c;
        if (!rst_n) begin
            m_word <= '0;
            m_irq  <= 1'b0;
        end else begin
            t = m_word;
            if (wr_en) t = (wr_data & 32'h00FF803F) | (m_word & ~wr_data & 32'h7F000000);
            t[31] = 1'b0;
            for (int n = 0; n < 7; n++)
                if (done_pulse[n] && t[16+n]) t[24+n] = 1'b1;
            c = (t[23] && t[30:24] != 0) || t[15];
            m_irq <= c && !m_word[31];
            t[31] = c;
            m_word <= t;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_data !== m_word || irq_pulse !== m_irq) begin
                errors++;
                $display("FAIL %s model: rd=%h irq=%b expected rd=%h irq=%b",
                         tag, rd_data, irq_pulse, m_word, m_irq);
            end
        end
    end

    task automatic step(input logic w, input logic [31:0] d, input logic [6:0] dn);
        wr_en = w; wr_data = d; done_pulse = dn;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; done_pulse = '0;
    endtask

    task automatic expect_out(input logic [31:0] er, input logic ei, input string req);
        checks++;
        if (rd_data !== er || irq_pulse !== ei) begin
            errors++;
            $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                     req, rd_data, irq_pulse, er, ei);
        end
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(32'h0, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(32'h0, 1'b0, "R1");

        tag = "R2"; step(1, 32'h00FF0000, 0); expect_out(32'h00FF0000, 0, "R2");
        tag = "R4"; step(0, 0, 7'h04);        expect_out(32'h84FF0000, 1, "R4 R6");
        tag = "R7"; step(0, 0, 7'h01);        expect_out(32'h85FF0000, 0, "R7");
        tag = "R3"; step(1, 32'h04FF0000, 0); expect_out(32'h81FF0000, 0, "R3");
        tag = "R5"; step(1, 32'h01FF0000, 0); expect_out(32'h00FF0000, 0, "R5");
        step(1, 32'h0, 0);                    expect_out(32'h0, 0, "R5");
        tag = "R4"; step(1, 32'h00020000, 0);
        step(0, 0, 7'h02);                    expect_out(32'h02020000, 0, "R4");
        step(0, 0, 7'h08);                    expect_out(32'h02020000, 0, "R4");
        tag = "R6"; step(1, 32'h00820000, 0); expect_out(32'h82820000, 1, "R6");
        step(0, 0, 0);                        expect_out(32'h82820000, 0, "R6");
        tag = "R9"; step(1, 32'h02000000, 0); expect_out(32'h0, 0, "R5");
        step(1, 32'h80000000, 0);             expect_out(32'h0, 0, "R9");
        tag = "R5"; step(1, 32'h00008000, 0); expect_out(32'h80008000, 1, "R5 R6");
        step(0, 0, 0);                        expect_out(32'h80008000, 0, "R6");
        tag = "R7"; step(1, 32'h00008000, 0); expect_out(32'h80008000, 0, "R7");
        step(1, 32'h0, 0);                    expect_out(32'h0, 0, "R5");
        tag = "R8"; step(1, 32'h00810000, 7'h01); expect_out(32'h81810000, 1, "R8");
        step(0, 0, 0);
        step(1, 32'h01810000, 7'h01);         expect_out(32'h81810000, 0, "R8");
        step(1, 32'h01800000, 7'h01);         expect_out(32'h00800000, 0, "R8");
        tag = "R2"; step(1, 32'h00007FFF, 0); expect_out(32'h0000003F, 0, "R2");
        tag = "R4"; step(1, 32'h00FF0000, 0);
        step(0, 0, 7'h7F);                    expect_out(32'hFFFF0000, 1, "R4");
        step(0, 0, 0);                        expect_out(32'hFFFF0000, 0, "R7");
        tag = "R1"; rst_n = 1'b0;
        @(negedge clk);                       expect_out(32'h0, 0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule